// File: doc/BRIEF.md
# Timer Event Generation and Status Flags

This block holds the command and flag logic of a small general-purpose timer that has one channel with a complementary output, a repetition counter and a break input. Software writes a one-cycle command word that carries self-clearing bits for update, capture 1, output-control update, trigger and break. The block merges these commands with the matching hardware events into four sticky status flags. It also produces a main-output-enable bit, a load strobe for the shadowed output-control bits, and a single level interrupt.

Update events can come from three sources: the software update command, a slave-mode counter reset, and counter overflow. Each source is gated by the update-disable and request-source controls. Overflow is also gated by the repetition counter. A minimal prescaled up-counter exists only to produce overflows. Flags stay set until software clears them by writing zeros to the status word.

Top module: `tmr_evt_gen`

## Requirements
- R1: After reset, flags_o is 0, moe_o is 0, cnt_o is 0, irq_o is 0, upd_o is 0, ctl_load_o is 0, and the active output-control bits are 0.
- R2: A command write with bit 7 set raises the break flag (flags_o[3]) and clears moe_o at the same clock edge. moe_set_i sets moe_o again.
- R3: A command write with bit 6 set raises the trigger flag (flags_o[2]). A command write with bit 1 set raises the capture flag (flags_o[1]). The trg_i and cap_i inputs set the same two flags.
- R4: When ctl_pre_i is 1, a command write with bit 5 set copies shd_en_i, shd_nen_i and shd_mode_i into act_en_o, act_nen_o and act_mode_o, and ctl_load_o pulses for one cycle. When ctl_pre_i is 0, the active bits follow the shadow inputs every cycle, and bit 5 produces no ctl_load_o pulse.
- R5: A command write with bit 0 set resets the counter and prescaler to 0 and reloads the repetition counter from rep_i. It raises the update flag (flags_o[0]) and pulses upd_o only when upd_src_i is 0 and upd_dis_i is 0.
- R6: A high slv_rst_i reinitialises the counter in the same way as R5, under the same flag gating.
- R7: With the counter enabled, the counter wraps at arr_i. An overflow raises the update flag only when the repetition count is 0 and upd_dis_i is 0; any other overflow decrements a nonzero repetition count. After a reinitialisation, the first update comes after (rep_i+1)*(arr_i+1)*(psc_i+1) enabled cycles.
- R8: While upd_dis_i is 1, overflows raise no update flag and the repetition count stays at 0. The next overflow after upd_dis_i returns to 0 produces an update.
- R9: A status write clears each flag whose bit is 0 in the written word. The bit positions are update 0, capture 1, trigger 6, break 7. A written 1 keeps the flag. A hardware set in the same cycle as a clear wins.
- R10: Command bits 15:8 and 4:2, and command bits written as 0, have no effect on flags, moe_o, the counter or ctl_load_o.
- R11: irq_o is 1 exactly when some flag is set and its matching bit in ie_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 16 | Command word |
| sts_we_i | input | 1 | Status word write strobe |
| sts_wdata_i | input | 16 | Status word, a 0 clears the flag |
| cnt_en_i | input | 1 | Counter enable |
| psc_i | input | 16 | Prescaler divide value minus one |
| arr_i | input | 16 | Counter wrap value |
| rep_i | input | 8 | Repetition reload value |
| upd_dis_i | input | 1 | Update disable |
| upd_src_i | input | 1 | Update request source, 1 limits updates to overflow |
| ctl_pre_i | input | 1 | Output-control preload enable |
| slv_rst_i | input | 1 | Slave-mode counter reset |
| cap_i | input | 1 | Hardware capture event |
| trg_i | input | 1 | Hardware trigger event |
| brk_i | input | 1 | Hardware break event |
| moe_set_i | input | 1 | Set main output enable |
| ie_i | input | 4 | Interrupt enables, same order as flags_o |
| shd_en_i | input | 1 | Shadow channel enable |
| shd_nen_i | input | 1 | Shadow complementary enable |
| shd_mode_i | input | 3 | Shadow output mode |
| flags_o | output | 4 | Flags {break, trigger, capture, update} |
| moe_o | output | 1 | Main output enable |
| irq_o | output | 1 | Interrupt line |
| upd_o | output | 1 | One-cycle update event pulse |
| cnt_o | output | 16 | Counter value |
| ctl_load_o | output | 1 | One-cycle output-control load pulse |
| act_en_o | output | 1 | Active channel enable |
| act_nen_o | output | 1 | Active complementary enable |
| act_mode_o | output | 3 | Active output mode |

## Verification
The assertions assume that arr_i, psc_i and rep_i stay constant while the counter runs. They also assume that ctl_pre_i does not change in the cycle of a control-update command. The stimulus changes these values only while cnt_en_i is low, and sets ctl_pre_i well before it issues any command. Flag and reload properties are checked one edge after their cause, so the stimulus drives every input on the falling edge and holds each command strobe for one cycle.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int CMD_W  = 16;
  localparam int NFLAG  = 4;
  localparam int B_UPD  = 0;
  localparam int B_CAP  = 1;
  localparam int B_CTL  = 5;
  localparam int B_TRG  = 6;
  localparam int B_BRK  = 7;
  localparam int F_UPD  = 0;
  localparam int F_CAP  = 1;
  localparam int F_TRG  = 2;
  localparam int F_BRK  = 3;

  typedef struct packed {
    logic brk;
    logic trg;
    logic ctl;
    logic cap;
    logic upd;
  } cmd_t;

  typedef struct packed {
    logic [2:0] mode;
    logic       nen;
    logic       en;
  } out_ctl_t;
endpackage

// File: rtl/tmr_evt_dec.sv
module tmr_evt_dec
  import tmr_evt_pkg::*;
(
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             sts_we_i,
  input  logic [CMD_W-1:0] sts_wdata_i,
  output cmd_t             cmd_o,
  output logic [NFLAG-1:0] clr_o
);
  always_comb begin
    cmd_o.upd = cmd_we_i & cmd_wdata_i[B_UPD];
    cmd_o.cap = cmd_we_i & cmd_wdata_i[B_CAP];
    cmd_o.ctl = cmd_we_i & cmd_wdata_i[B_CTL];
    cmd_o.trg = cmd_we_i & cmd_wdata_i[B_TRG];
    cmd_o.brk = cmd_we_i & cmd_wdata_i[B_BRK];
  end

  // status bits share the command positions; a written 0 clears
  always_comb begin
    clr_o[F_UPD] = sts_we_i & ~sts_wdata_i[B_UPD];
    clr_o[F_CAP] = sts_we_i & ~sts_wdata_i[B_CAP];
    clr_o[F_TRG] = sts_we_i & ~sts_wdata_i[B_TRG];
    clr_o[F_BRK] = sts_we_i & ~sts_wdata_i[B_BRK];
  end
endmodule

// File: rtl/tmr_evt_cnt.sv
module tmr_evt_cnt #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             reinit_i,
  input  logic             upd_dis_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_upd_o
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] rep_q;
  logic tick, ovf;

  assign tick      = en_i && !reinit_i && (psc_q == psc_i);
  assign ovf       = tick && (cnt_q == arr_i);
  assign ovf_upd_o = ovf && (rep_q == '0) && !upd_dis_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      cnt_q <= '0;
      rep_q <= '0;
    end else if (reinit_i) begin
      psc_q <= '0;
      cnt_q <= '0;
      rep_q <= rep_i;
    end else if (en_i) begin
      psc_q <= tick ? '0 : psc_q + 1'b1;
      if (tick) cnt_q <= ovf ? '0 : cnt_q + 1'b1;
      if (ovf_upd_o)               rep_q <= rep_i;
      else if (ovf && rep_q != '0) rep_q <= rep_q - 1'b1;
    end
  end

  p_reinit_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (cnt_q == '0) && (psc_q == '0));
  p_rep_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reinit_i || ovf_upd_o) |=> rep_q == $past(rep_i));
  p_udis_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && upd_dis_i && rep_q == '0) |=> rep_q == '0);
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int NF = 4,
  parameter int BRK_IDX = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          moe_set_i,
  output logic [NF-1:0] flag_o,
  output logic          moe_o
);
  logic [NF-1:0] flag_q;
  logic          moe_q;

  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[k] <= 1'b0;
      else if (set_i[k]) flag_q[k] <= 1'b1;   // hardware set beats clear
      else if (clr_i[k]) flag_q[k] <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_q[k]);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !clr_i[k]) |=> flag_q[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              moe_q <= 1'b0;
    else if (set_i[BRK_IDX])  moe_q <= 1'b0;
    else if (moe_set_i)       moe_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign moe_o  = moe_q;

  p_brk_moe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[BRK_IDX] |=> flag_q[BRK_IDX] && !moe_q);
endmodule

// File: rtl/tmr_evt_gen.sv
module tmr_evt_gen
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             sts_we_i,
  input  logic [CMD_W-1:0] sts_wdata_i,
  input  logic             cnt_en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [REP_W-1:0] rep_i,
  input  logic             upd_dis_i,
  input  logic             upd_src_i,
  input  logic             ctl_pre_i,
  input  logic             slv_rst_i,
  input  logic             cap_i,
  input  logic             trg_i,
  input  logic             brk_i,
  input  logic             moe_set_i,
  input  logic [NFLAG-1:0] ie_i,
  input  logic             shd_en_i,
  input  logic             shd_nen_i,
  input  logic [2:0]       shd_mode_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             moe_o,
  output logic             irq_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ctl_load_o,
  output logic             act_en_o,
  output logic             act_nen_o,
  output logic [2:0]       act_mode_o
);
  cmd_t             cmd;
  logic [NFLAG-1:0] clr, set;
  logic             reinit, sw_upd, ovf_upd, upd_evt;
  logic             upd_q, load_q;
  out_ctl_t         shd, act_q;

  tmr_evt_dec u_dec (
    .cmd_we_i   (cmd_we_i),
    .cmd_wdata_i(cmd_wdata_i),
    .sts_we_i   (sts_we_i),
    .sts_wdata_i(sts_wdata_i),
    .cmd_o      (cmd),
    .clr_o      (clr)
  );

  assign reinit  = cmd.upd | slv_rst_i;
  assign sw_upd  = reinit & ~upd_src_i & ~upd_dis_i;
  assign upd_evt = sw_upd | ovf_upd;

  tmr_evt_cnt #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .psc_i    (psc_i),
    .arr_i    (arr_i),
    .rep_i    (rep_i),
    .reinit_i (reinit),
    .upd_dis_i(upd_dis_i),
    .cnt_o    (cnt_o),
    .ovf_upd_o(ovf_upd)
  );

  always_comb begin
    set        = '0;
    set[F_UPD] = upd_evt;
    set[F_CAP] = cmd.cap | cap_i;
    set[F_TRG] = cmd.trg | trg_i;
    set[F_BRK] = cmd.brk | brk_i;
  end

  tmr_evt_flags #(.NF(NFLAG), .BRK_IDX(F_BRK)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .clr_i    (clr),
    .moe_set_i(moe_set_i),
    .flag_o   (flags_o),
    .moe_o    (moe_o)
  );

  assign shd = '{mode: shd_mode_i, nen: shd_nen_i, en: shd_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      load_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      load_q <= cmd.ctl & ctl_pre_i;
      upd_q  <= upd_evt;
      if (!ctl_pre_i || cmd.ctl) act_q <= shd;
    end
  end

  assign irq_o      = |(flags_o & ie_i);
  assign upd_o      = upd_q;
  assign ctl_load_o = load_q;
  assign act_en_o   = act_q.en;
  assign act_nen_o  = act_q.nen;
  assign act_mode_o = act_q.mode;

  p_load_copies_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.ctl && ctl_pre_i) |=> ctl_load_o && act_q == $past(shd));
  p_no_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_pre_i |=> !ctl_load_o);
  p_upd_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> flags_o[F_UPD]);
endmodule

// File: tb/tmr_evt_gen_tb_top.sv
module tmr_evt_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_we = 0, sts_we = 0, cnt_en = 0;
  logic [15:0] cmd_wd = 0, sts_wd = 0, psc = 0, arr = 3;
  logic [7:0]  rep = 1;
  logic        udis = 0, usrc = 0, cpre = 0, slv = 0, cap = 0, trg = 0, brk = 0, moe_set = 0;
  logic [3:0]  ie = 0;
  logic        s_en = 0, s_nen = 0;
  logic [2:0]  s_mode = 0;
  logic [3:0]  flags;
  logic        moe, irq, upd, cload, a_en, a_nen;
  logic [15:0] cnt;
  logic [2:0]  a_mode;
  int n_chk = 0, n_fail = 0;

  tmr_evt_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd), .cnt_en_i(cnt_en), .psc_i(psc),
    .arr_i(arr), .rep_i(rep), .upd_dis_i(udis), .upd_src_i(usrc), .ctl_pre_i(cpre),
    .slv_rst_i(slv), .cap_i(cap), .trg_i(trg), .brk_i(brk), .moe_set_i(moe_set),
    .ie_i(ie), .shd_en_i(s_en), .shd_nen_i(s_nen), .shd_mode_i(s_mode),
    .flags_o(flags), .moe_o(moe), .irq_o(irq), .upd_o(upd), .cnt_o(cnt),
    .ctl_load_o(cload), .act_en_o(a_en), .act_nen_o(a_nen), .act_mode_o(a_mode));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd_wr(logic [15:0] d);
    @(negedge clk); cmd_we = 1; cmd_wd = d;
    @(negedge clk); cmd_we = 0; cmd_wd = 0;
  endtask

  task automatic sts_wr(logic [15:0] d);
    @(negedge clk); sts_we = 1; sts_wd = d;
    @(negedge clk); sts_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 flags", flags, 0); chk("R1 moe", moe, 0); chk("R1 cnt", cnt, 0);
    chk("R1 irq", irq, 0); chk("R1 upd", upd, 0); chk("R1 load", cload, 0);
    chk("R1 act", {a_en, a_nen, a_mode}, 0);
  endtask

  task automatic t_break;
    @(negedge clk); moe_set = 1; @(negedge clk); moe_set = 0;
    chk("R2 moe set", moe, 1);
    cmd_wr(16'h0080);
    chk("R2 brk flag", flags[3], 1); chk("R2 moe clr", moe, 0);
    sts_wr(16'h0000);
    @(negedge clk); moe_set = 1; @(negedge clk); moe_set = 0;
  endtask

  task automatic t_trg_cap;
    cmd_wr(16'h0040); chk("R3 trg", flags, 4'b0100);
    cmd_wr(16'h0002); chk("R3 cap", flags, 4'b0110);
    sts_wr(16'h0000); chk("R9 clear all", flags, 0);
    @(negedge clk); trg = 1; cap = 1; @(negedge clk); trg = 0; cap = 0;
    chk("R3 hw trg cap", flags, 4'b0110);
    sts_wr(16'h0000);
  endtask

  task automatic t_ctl;
    s_en = 1; s_nen = 0; s_mode = 3'd6; @(negedge clk);
    chk("R4 follow no preload", {a_en, a_nen, a_mode}, {1'b1, 1'b0, 3'd6});
    cmd_wr(16'h0020); chk("R4 no strobe", cload, 0);
    cpre = 1; @(negedge clk);
    s_en = 0; s_nen = 1; s_mode = 3'd3; @(negedge clk); @(negedge clk);
    chk("R4 held", {a_en, a_nen, a_mode}, {1'b1, 1'b0, 3'd6});
    @(negedge clk); cmd_we = 1; cmd_wd = 16'h0020;
    @(negedge clk); cmd_we = 0; cmd_wd = 0;
    chk("R4 strobe", cload, 1);
    chk("R4 loaded", {a_en, a_nen, a_mode}, {1'b0, 1'b1, 3'd3});
    @(negedge clk); chk("R4 strobe one cycle", cload, 0);
  endtask

  task automatic t_reserved;
    logic [15:0] c0;
    @(negedge clk); cnt_en = 1; @(negedge clk); @(negedge clk); cnt_en = 0;
    c0 = cnt;
    cmd_wr(16'hFF1C);
    chk("R10 flags", flags, 0); chk("R10 moe", moe, 1);
    chk("R10 cnt", cnt, c0); chk("R10 load", cload, 0);
    cmd_wr(16'h0000);
    chk("R10 zero write", {flags, moe}, 5'b00001); chk("R10 zero cnt", cnt, c0);
  endtask

  task automatic t_sw_upd;
    usrc = 1; cmd_wr(16'h0001);
    chk("R5 src gate", flags[0], 0); chk("R5 reinit", cnt, 0);
    usrc = 0; udis = 1; cmd_wr(16'h0001);
    chk("R5 dis gate", flags[0], 0);
    udis = 0;
    @(negedge clk); cnt_en = 1; @(negedge clk); @(negedge clk); cnt_en = 0;
    @(negedge clk); cmd_we = 1; cmd_wd = 16'h0001;
    @(negedge clk); cmd_we = 0; cmd_wd = 0;
    chk("R5 flag", flags[0], 1); chk("R5 upd pulse", upd, 1); chk("R5 cnt", cnt, 0);
    @(negedge clk); chk("R5 pulse ends", upd, 0);
    sts_wr(16'hFFFE);
    @(negedge clk); cnt_en = 1; @(negedge clk); cnt_en = 0;
    @(negedge clk); slv = 1; @(negedge clk); slv = 0;
    chk("R6 slave flag", flags[0], 1); chk("R6 slave cnt", cnt, 0);
    sts_wr(16'h0000);
    usrc = 1; @(negedge clk); slv = 1; @(negedge clk); slv = 0; usrc = 0;
    chk("R6 slave gated", flags[0], 0);
  endtask

  task automatic t_overflow;
    int n;
    psc = 0; arr = 3; rep = 1;
    usrc = 1; cmd_wr(16'h0001); usrc = 0;
    @(negedge clk); cnt_en = 1; n = 0;
    for (int i = 0; i < 40 && !flags[0]; i++) begin @(negedge clk); n++; end
    cnt_en = 0;
    chk("R7 cycles rep1", n, 8); chk("R7 wrap", cnt, 0);
    sts_wr(16'h0000);
    psc = 1; arr = 2; rep = 0;
    usrc = 1; cmd_wr(16'h0001); usrc = 0;
    @(negedge clk); cnt_en = 1; n = 0;
    for (int i = 0; i < 40 && !flags[0]; i++) begin @(negedge clk); n++; end
    cnt_en = 0;
    chk("R7 cycles psc", n, 6);
    sts_wr(16'h0000);
  endtask

  task automatic t_udis;
    int n;
    psc = 0; arr = 3; rep = 1;
    usrc = 1; cmd_wr(16'h0001); usrc = 0;
    udis = 1;
    @(negedge clk); cnt_en = 1;
    repeat (12) @(negedge clk);
    cnt_en = 0;
    chk("R8 no flag", flags[0], 0); chk("R8 cnt", cnt, 0);
    udis = 0; @(negedge clk); cnt_en = 1; n = 0;
    for (int i = 0; i < 40 && !flags[0]; i++) begin @(negedge clk); n++; end
    cnt_en = 0;
    chk("R8 next update", n, 4);
    sts_wr(16'h0000);
  endtask

  task automatic t_clear_irq;
    cmd_wr(16'h0042);
    sts_wr(16'h0040); chk("R9 keep on 1", flags, 4'b0100);
    @(negedge clk); sts_we = 1; sts_wd = 0; cmd_we = 1; cmd_wd = 16'h0040;
    @(negedge clk); sts_we = 0; cmd_we = 0; cmd_wd = 0;
    chk("R9 set wins", flags, 4'b0100);
    ie = 4'b0100; @(negedge clk); chk("R11 irq on", irq, 1);
    ie = 4'b1011; @(negedge clk); chk("R11 masked", irq, 0);
    ie = 4'b0100; sts_wr(16'h0000); chk("R11 cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_break(); t_trg_cap(); t_ctl(); t_reserved();
    t_sw_upd(); t_overflow(); t_udis(); t_clear_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule